// File: doc/BRIEF.md
# Link-Reserved Load and Conditional Store Unit

This unit handles the memory half of reserved-load and conditional-store operations in a processor with a 64-bit data bus. The pipeline gives it a base register value, a signed 16-bit displacement, a 2-bit operation code and the store operand. The unit adds the base and the displacement to form the address and checks that the address is aligned for the access size. It keeps one reservation (link) bit. For word accesses it picks the right 32-bit half of the 64-bit bus, taking both the core's byte order and a reverse-order mode into account. It then runs one transfer on a simple request/response memory port.

A reserved load returns the loaded value and sets the link bit. A conditional store writes memory only while the link bit is set. Pass or fail, the destination register receives the link bit value. A misaligned address raises an address error and starts no transfer. The link bit is cleared by reset, by an exception-return pulse and by an external kill input, for example a snoop hit seen elsewhere. A one-cycle `done` pulse tells the pipeline that `result` and `addr_err` are valid.

Top module: `llsc_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to the address width. For a doubleword access, and for a word access with `reverse_endian`=0, `mem_addr` equals that address.
- R2: Operation codes are 0 = reserved word load, 1 = reserved doubleword load, 2 = conditional word store and 3 = conditional doubleword store. A word access whose address bits [1:0] are not zero, or a doubleword access whose bits [2:0] are not zero, gives `done` with `addr_err`=1 and `result`=0. Such an access starts no memory transfer and leaves the link bit unchanged.
- R3: An aligned reserved load sets the link bit when its memory response arrives. A later conditional store then succeeds.
- R4: A word load reads byte lane L = {addr[2] XOR `big_endian`, 2'b00} of `mem_rdata`, counted from the low end in bytes. The 32 bits starting at byte L are returned sign-extended to 64 bits.
- R5: A doubleword load returns `mem_rdata` unchanged.
- R6: A conditional store issues a write only when the link bit is 1 at the cycle the request is accepted. `result` is 1 on success and 0 on failure. A conditional store does not change the link bit.
- R7: A word store drives the low 32 bits of `req_sdata` shifted left by 8·L bits (L as in R4) on `mem_wdata`, with `mem_wstrb` = 8'h0F << L. Bit b of the strobe enables byte b. A doubleword store drives `req_sdata` with `mem_wstrb` = 8'hFF.
- R8: In a word access with `reverse_endian`=1, `mem_addr` is the effective address with bit 2 inverted. The lane choice of R4 and R7 is not affected. Doubleword addresses are never altered.
- R9: The link bit is 0 after reset. It is cleared in any cycle in which `eret_pulse` or `link_kill` is high. A clear in the same cycle as a load response wins over the set.
- R10: `mem_req` rises the cycle after acceptance and holds with a stable address until the cycle in which `mem_resp` is high. `done` is a one-cycle pulse: it comes the cycle after that response, or the cycle right after acceptance when no transfer is made.
- R11: `req_ready` is high only when the unit is idle. A request presented while it is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_op | input | 2 | Operation code (see R2) |
| req_base | input | ADDR_W | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_sdata | input | 64 | Store operand |
| big_endian | input | 1 | Core byte order is big-endian |
| reverse_endian | input | 1 | Reverse-order mode for word addresses |
| eret_pulse | input | 1 | Exception return, clears link |
| link_kill | input | 1 | External reservation invalidate |
| mem_req | output | 1 | Memory transfer pending |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | ADDR_W | Physical byte address |
| mem_wdata | output | 64 | Write data, lane-aligned |
| mem_wstrb | output | 8 | Byte write enables |
| mem_resp | input | 1 | Memory completes the transfer |
| mem_rdata | input | 64 | Read data, valid with `mem_resp` |
| done | output | 1 | Operation complete pulse |
| addr_err | output | 1 | Alignment error, valid with `done` |
| result | output | 64 | Destination register value, valid with `done` |

## Verification
The bench first runs directed sequences for the link bit: reserve then store, store after reset, store after an exception return, store after a kill, and a kill that lands in the same cycle as the load response. These separate a correct set/clear priority from a reversed one. It then sweeps every operation code over all eight low address offsets, both byte orders, both reverse-mode settings and response latencies of zero to two cycles. The sweep compares results, addresses, strobes, memory contents and completion timing with values worked out from the requirements. Misaligned offsets separate the word and doubleword alignment rules. The byte-order and reverse-mode settings separate a lane picked from the effective address from one picked from the altered physical address. Holding a second request through a busy operation shows whether requests are taken while the unit is not ready.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    localparam int BUS_W   = 64;
    localparam int WORD_W  = 32;
    localparam int OFF_W   = 16;
    localparam int BYTES   = BUS_W / 8;
    localparam int LANE_W  = $clog2(BYTES);
    localparam int OP_W    = 2;

    typedef enum logic [OP_W-1:0] {
        OP_RES_W  = 2'd0,
        OP_RES_D  = 2'd1,
        OP_COND_W = 2'd2,
        OP_COND_D = 2'd3
    } llsc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_DONE = 2'd2
    } llsc_state_e;

    typedef struct packed {
        logic              misaligned;
        logic [LANE_W-1:0] lane;
    } acc_info_t;

    function automatic logic is_store(llsc_op_e op);
        return op[1];
    endfunction

    function automatic logic is_dword(llsc_op_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/llsc_agen.sv
module llsc_agen
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  llsc_op_e          op,
    input  logic              big_endian,
    input  logic              reverse_endian,
    output logic [ADDR_W-1:0] paddr,
    output acc_info_t         info
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] ea;

    always_comb begin
        ea = base + {{EXT_W{offset[OFF_W-1]}}, offset};
        if (is_dword(op)) begin
            info.misaligned = |ea[LANE_W-1:0];
            info.lane       = '0;
            paddr           = ea;
        end else begin
            info.misaligned = |ea[LANE_W-2:0];
            info.lane       = {ea[LANE_W-1] ^ big_endian, {(LANE_W-1){1'b0}}};
            paddr           = {ea[ADDR_W-1:LANE_W], ea[LANE_W-1] ^ reverse_endian,
                               ea[LANE_W-2:0]};
        end
    end
endmodule

// File: rtl/llsc_lane.sv
module llsc_lane
    import llsc_pkg::*;
(
    input  llsc_op_e          op,
    input  logic [LANE_W-1:0] lane,
    input  logic [BUS_W-1:0]  rdata,
    input  logic [BUS_W-1:0]  sdata,
    output logic [BUS_W-1:0]  load_val,
    output logic [BUS_W-1:0]  wdata,
    output logic [BYTES-1:0]  wstrb
);
    localparam int WBYTES = WORD_W / 8;

    logic [BUS_W-1:0] shifted;
    logic [LANE_W+2:0] bitpos;

    always_comb begin
        bitpos  = {lane, 3'b000};
        shifted = rdata >> bitpos;
        if (is_dword(op)) begin
            load_val = rdata;
            wdata    = sdata;
            wstrb    = '1;
        end else begin
            load_val = {{(BUS_W-WORD_W){shifted[WORD_W-1]}}, shifted[WORD_W-1:0]};
            wdata    = {{(BUS_W-WORD_W){1'b0}}, sdata[WORD_W-1:0]} << bitpos;
            wstrb    = {{(BYTES-WBYTES){1'b0}}, {WBYTES{1'b1}}} << lane;
        end
    end
endmodule

// File: rtl/llsc_link.sv
module llsc_link (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic link_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            link_o <= 1'b0;
        end else if (set_i) begin
            link_o <= 1'b1;
        end
    end
endmodule

// File: rtl/llsc_unit.sv
module llsc_unit
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OP_W-1:0]   req_op,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [BUS_W-1:0]  req_sdata,
    input  logic              big_endian,
    input  logic              reverse_endian,
    input  logic              eret_pulse,
    input  logic              link_kill,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BUS_W-1:0]  mem_wdata,
    output logic [BYTES-1:0]  mem_wstrb,
    input  logic              mem_resp,
    input  logic [BUS_W-1:0]  mem_rdata,
    output logic              done,
    output logic              addr_err,
    output logic [BUS_W-1:0]  result
);
    llsc_state_e       state_q;
    llsc_op_e          op_in, op_q;
    logic [ADDR_W-1:0] pa_c, pa_q;
    acc_info_t         info_c;
    logic [LANE_W-1:0] lane_q;
    logic [BUS_W-1:0]  sdata_q, res_q, load_val;
    logic              err_q, link, link_set, accept;

    assign op_in  = llsc_op_e'(req_op);
    assign accept = req_valid && (state_q == ST_IDLE);

    llsc_agen #(.ADDR_W(ADDR_W)) u_agen (
        .base           (req_base),
        .offset         (req_offset),
        .op             (op_in),
        .big_endian     (big_endian),
        .reverse_endian (reverse_endian),
        .paddr          (pa_c),
        .info           (info_c)
    );

    llsc_lane u_lane (
        .op       (op_q),
        .lane     (lane_q),
        .rdata    (mem_rdata),
        .sdata    (sdata_q),
        .load_val (load_val),
        .wdata    (mem_wdata),
        .wstrb    (mem_wstrb)
    );

    assign link_set = (state_q == ST_MEM) && mem_resp && !is_store(op_q);

    llsc_link u_link (
        .clk    (clk),
        .rst    (rst),
        .set_i  (link_set),
        .clr_i  (eret_pulse || link_kill),
        .link_o (link)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_RES_W;
            pa_q    <= '0;
            lane_q  <= '0;
            sdata_q <= '0;
            res_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    op_q    <= op_in;
                    pa_q    <= pa_c;
                    lane_q  <= info_c.lane;
                    sdata_q <= req_sdata;
                    res_q   <= '0;
                    err_q   <= info_c.misaligned;
                    if (info_c.misaligned || (is_store(op_in) && !link)) begin
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_MEM;
                    end
                end
                ST_MEM: if (mem_resp) begin
                    res_q   <= is_store(op_q) ? {{(BUS_W-1){1'b0}}, 1'b1} : load_val;
                    state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_req   = (state_q == ST_MEM);
    assign mem_we    = mem_req && is_store(op_q);
    assign mem_addr  = pa_q;
    assign done      = (state_q == ST_DONE);
    assign addr_err  = done && err_q;
    assign result    = res_q;
endmodule

// File: rtl/llsc_unit_chk.sv
module llsc_unit_chk
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [OP_W-1:0]   req_op,
    input logic [2:0]        base_lo,
    input logic [2:0]        off_lo,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BYTES-1:0]  mem_wstrb,
    input logic              mem_resp,
    input logic              done,
    input logic              addr_err,
    input logic [BUS_W-1:0]  result
);
    logic [2:0] ea_lo;
    logic       mis;
    assign ea_lo = base_lo + off_lo;
    assign mis   = req_op[0] ? (ea_lo != 3'd0) : (ea_lo[1:0] != 2'd0);

    a_r2_misalign_no_xfer: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && mis) |=> (!mem_req && done && addr_err));

    a_r2_err_zero_result: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> (result == '0));

    a_r10_done_after_resp: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_resp) |=> (done && !mem_req));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_resp) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (mem_req || done) |-> !req_ready);

    a_r7_strobe_shape: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($countones(mem_wstrb) == 4 || $countones(mem_wstrb) == 8));
endmodule

bind llsc_unit llsc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .base_lo   (req_base[2:0]),
    .off_lo    (req_offset[2:0]),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wstrb (mem_wstrb),
    .mem_resp  (mem_resp),
    .done      (done),
    .addr_err  (addr_err),
    .result    (result)
);

// File: tb/tb_llsc_unit.sv
module tb_llsc_unit;
    localparam int AW = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst, req_valid, req_ready, big_endian, reverse_endian;
    logic          eret_pulse, kill_task, kill_resp, link_kill;
    logic [1:0]    req_op;
    logic [AW-1:0] req_base, mem_addr;
    logic [15:0]   req_offset;
    logic [63:0]   req_sdata, mem_wdata, mem_rdata, result;
    logic [7:0]    mem_wstrb;
    logic          mem_req, mem_we, mem_resp, done, addr_err;

    assign link_kill = kill_task | kill_resp;

    llsc_unit #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_base(req_base), .req_offset(req_offset),
        .req_sdata(req_sdata), .big_endian(big_endian),
        .reverse_endian(reverse_endian), .eret_pulse(eret_pulse),
        .link_kill(link_kill), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_resp(mem_resp), .mem_rdata(mem_rdata), .done(done),
        .addr_err(addr_err), .result(result)
    );

    int checks = 0, errors = 0;
    logic [63:0] mem [8];
    logic [63:0] shadow [8];
    int lat = 0, wait_cnt = 0, writes = 0, xfers = 0;
    bit kill_on_resp = 0;
    logic [AW-1:0] last_addr = '0;
    bit link_ref = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // memory responder
    initial begin
        mem_resp = 0; mem_rdata = '0; kill_resp = 0;
        forever begin
            @(negedge clk);
            kill_resp = 0;
            if (mem_resp) mem_resp = 0;
            else if (mem_req) begin
                if (wait_cnt < lat) wait_cnt++;
                else begin
                    automatic int idx = int'(mem_addr[5:3]);
                    wait_cnt = 0;
                    mem_resp = 1;
                    last_addr = mem_addr;
                    xfers++;
                    if (mem_we) begin
                        for (int b = 0; b < 8; b++)
                            if (mem_wstrb[b]) mem[idx][8*b +: 8] = mem_wdata[8*b +: 8];
                        writes++;
                    end
                    mem_rdata = mem[idx];
                    if (kill_on_resp) kill_resp = 1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic run_op(input logic [1:0] op, input logic [63:0] base,
                          input logic [15:0] off, input logic [63:0] sd,
                          output logic [63:0] res, output logic err, output int ncyc);
        @(negedge clk);
        req_valid = 1; req_op = op; req_base = base; req_offset = off; req_sdata = sd;
        @(negedge clk);
        req_valid = 0; ncyc = 0;
        while (!done && ncyc < 50) begin @(negedge clk); ncyc++; end
        res = result; err = addr_err;
    endtask

    task automatic pulse_kill();
        @(negedge clk); kill_task = 1; @(negedge clk); kill_task = 0;
    endtask

    // full reference check of one operation
    task automatic exercise(input logic [1:0] op, input logic [63:0] base,
                            input logic [15:0] off, input logic [63:0] sd);
        logic [63:0] ea, pa, eres, res, w;
        logic err, mis, xfer;
        int ncyc, lane, x0, w0, idx;
        ea  = base + {{48{off[15]}}, off};
        mis = op[0] ? (ea[2:0] != 0) : (ea[1:0] != 0);
        xfer = !mis && !(op[1] && !link_ref);
        pa  = op[0] ? ea : (ea ^ (reverse_endian ? 64'd4 : 64'd0));
        lane = op[0] ? 0 : ((ea[2] ^ big_endian) ? 4 : 0);
        idx = int'(pa[5:3]);
        eres = '0;
        if (xfer && !op[1]) begin
            w = shadow[idx] >> (8*lane);
            eres = op[0] ? shadow[idx] : {{32{w[31]}}, w[31:0]};
            link_ref = 1;
        end
        if (xfer && op[1]) begin
            eres = 64'd1;
            if (op[0]) shadow[idx] = sd;
            else for (int b = 0; b < 4; b++) shadow[idx][8*(lane+b) +: 8] = sd[8*b +: 8];
        end
        x0 = xfers; w0 = writes;
        run_op(op, base, off, sd, res, err, ncyc);
        chk(err == mis, "R2 addr_err", {63'd0, err}, {63'd0, mis});
        if (!op[1]) chk(res == eres, op[0] ? "R5 dword load" : "R4 word load", res, eres);
        else chk(res == eres, "R6 store result", res, eres);
        chk((xfers - x0) == (xfer ? 1 : 0), "R2 R6 transfer count",
            64'(xfers - x0), xfer ? 64'd1 : 64'd0);
        chk(ncyc == (xfer ? 1 + lat : 0), "R10 done timing", 64'(ncyc),
            xfer ? 64'(1 + lat) : 64'd0);
        if (xfer) begin
            if (!op[0] && reverse_endian) chk(last_addr == pa, "R8 reverse address", last_addr, pa);
            else chk(last_addr == pa, "R1 effective address", last_addr, pa);
        end
        if (op[1]) begin
            chk(mem[idx] == shadow[idx], "R7 stored memory", mem[idx], shadow[idx]);
            chk((writes - w0) == (xfer ? 1 : 0), "R6 write suppressed",
                64'(writes - w0), xfer ? 64'd1 : 64'd0);
        end
    endtask

    initial begin
        logic [63:0] res;
        logic err;
        int ncyc, w0, d0;
        logic [31:0] lfsr;
        rst = 1; req_valid = 0; req_op = 0; req_base = '0; req_offset = '0;
        req_sdata = '0; big_endian = 0; reverse_endian = 0; eret_pulse = 0;
        kill_task = 0;
        for (int k = 0; k < 8; k++) begin
            mem[k] = 64'hF1E2_D3C4_85A6_B7C8 ^ (64'h1111_0000_0303_0000 * k);
            shadow[k] = mem[k];
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready && !done && !mem_req, "R9 reset state",
            {61'd0, req_ready, done, mem_req}, 64'd4);

        // R9: conditional store right after reset fails
        link_ref = 0;
        exercise(2'd3, 64'h100, 16'h0008, 64'hAAAA_5555_1234_5678);
        // R3: reserve then store succeeds
        exercise(2'd1, 64'h100, 16'h0008, 64'h0);
        exercise(2'd3, 64'h100, 16'h0008, 64'hAAAA_5555_1234_5678);
        // R6: link not consumed by a successful store
        exercise(2'd2, 64'h100, 16'h0004, 64'h0BAD_F00D);
        // R9: exception return clears
        @(negedge clk); eret_pulse = 1; @(negedge clk); eret_pulse = 0; link_ref = 0;
        exercise(2'd2, 64'h100, 16'h0000, 64'h1357_9BDF);
        // R9: kill input clears
        exercise(2'd0, 64'h100, 16'h0000, 64'h0);
        pulse_kill(); link_ref = 0;
        exercise(2'd3, 64'h108, 16'hFFF8, 64'h2222);
        // R9: clear wins over set in the response cycle
        kill_on_resp = 1;
        run_op(2'd0, 64'h120, 16'h0, 64'h0, res, err, ncyc);
        kill_on_resp = 0;
        w0 = writes;
        run_op(2'd2, 64'h120, 16'h0, 64'h77, res, err, ncyc);
        chk(res == 0 && writes == w0, "R9 clear beats set", res, 64'd0);
        link_ref = 0;

        // R11: requests while busy are ignored
        lat = 3; w0 = writes;
        @(negedge clk);
        req_valid = 1; req_op = 2'd0; req_base = 64'h140; req_offset = 16'h0;
        @(negedge clk);
        req_op = 2'd3; req_sdata = 64'hDEAD;
        chk(!req_ready, "R11 not ready while busy", {63'd0, req_ready}, 64'd0);
        while (!done) @(negedge clk);
        req_valid = 0;
        d0 = 0;
        repeat (6) begin @(negedge clk); if (done || mem_req) d0++; end
        chk(d0 == 0 && writes == w0, "R11 busy request ignored", 64'(d0), 64'd0);
        link_ref = 1;
        lat = 0;

        // sweep: ops x low offsets x byte order x reverse mode x latency
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 256; i++) begin
            logic [63:0] base;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            big_endian = i[2]; reverse_endian = i[3];
            lat = i % 3;
            if (i % 7 == 3) begin pulse_kill(); link_ref = 0; end
            base = 64'h4000 + {58'd0, lfsr[2:0], 3'b000};
            exercise(i[1:0], base, 16'hFFF8 + {13'd0, i[6:4]}, {lfsr, lfsr ^ 32'(i)});
        end
        lat = 0;

        summary();
        $finish;
    end
endmodule